// File: doc/BRIEF.md
# Card Data FIFO Packing Engine

This block sits between a processor register window and the byte-wide data port of a memory card. A 16-word FIFO of 32-bit entries buffers the data. Software programs a byte length, then writes the data control register with the enable bit set and a direction bit. In the card-to-host direction, bytes from the card are gathered into words and pushed into the FIFO. The first byte lands in the lowest byte lane. A short final word is pushed with zeros above the last byte. In the host-to-card direction, software pushes words, and the engine sends them to the card one byte at a time, lowest lane first.

The engine counts the remaining bytes and also reports them as a rounded-up word count. It flags the end of a block and clears its own enable when the count reaches zero and the FIFO is empty. Reading a FIFO word holds off further card-to-FIFO transfers. The hold lasts until software reads either the status register or the word-count register. Slow drivers use this to drain the FIFO without new data arriving in the middle. The card side is a plain byte handshake: valid and ready.

Register map (byte offsets, word aligned): 0x00 length, 0x04 control (bit 0 enable, bit 1 direction, 1 = card to FIFO), 0x08 remaining bytes, 0x0C status, 0x10 word count, 0x80 to 0xBC FIFO data. Status bits: bit 0 block end, bit 1 receive active, bit 2 transmit active, bit 3 FIFO empty, bit 4 FIFO full.

Top module: `cardFifoEngine`

## Requirements
- R1: After synchronous reset, status reads 0x08 (FIFO empty only), and remaining bytes, word count and control all read zero. Card ready and card valid outputs are low.
- R2: In the card-to-FIFO direction, the k-th byte of word w of a transfer occupies bits 8k+7:8k of the FIFO word. Words are read out in arrival order.
- R3: When the byte count ends partway through a word, that word is still pushed. Its unused upper bytes read as zero.
- R4: Writing control with bit 0 set loads the remaining count from the length register. The count then drops by one for each byte exchanged with the card, and it reads back at 0x08.
- R5: The word-count register reads (remaining + 3) >> 2.
- R6: A read of the FIFO data window that pops a word stops card-to-FIFO transfers. Reading 0x08 does not end the hold. Reading status or word count does, and transfers then resume.
- R7: Once remaining is zero and the FIFO is empty, the enable bit clears, block end sets, and the receive and transmit active flags read zero. This includes a zero-length transfer.
- R8: Reading the FIFO window while the FIFO is empty returns zero, pops nothing and starts no hold.
- R9: A FIFO window write is dropped unless the engine is enabled in the host-to-card direction, remaining is non-zero and the FIFO is not full.
- R10: In the host-to-card direction, every byte is presented with card valid and is held stable until card ready. Bytes go out lowest lane first, and exactly as many go out as the programmed length.
- R11: All sixteen word addresses from 0x80 to 0xBC reach the same FIFO.
- R12: A card byte is accepted only while card valid is high, and only while the FIFO is not full. A full FIFO stalls the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (side effects at the clock edge) |
| regAddr | input | 8 | Register byte offset |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data, valid in the cycle of regRdEn |
| cardRxValid | input | 1 | Card offers a byte |
| cardRxByte | input | 8 | Byte from the card |
| cardRxReady | output | 1 | Engine accepts a card byte |
| cardTxValid | output | 1 | Engine offers a byte to the card |
| cardTxByte | output | 8 | Byte to the card |
| cardTxReady | input | 1 | Card accepts the offered byte |

## Verification
The bench uses the default parameters: 16 FIFO words of 32 bits and a 16-bit length. With these values a transfer of 80 bytes fills the FIFO after 64 bytes, which lets the bench reach both the full-FIFO stall and the read hold. Lengths up to 64 fit entirely in the FIFO, so the random runs can vary lengths that are not multiples of four across both directions, with random card valid and ready patterns. The 16-bit length also allows the largest count, 65535, to be checked in the rounded word count.

// File: rtl/cardFifoPkg.sv
package cardFifoPkg;

  // Strobes from the control to the datapath, one cycle each.
  typedef struct packed {
    logic busPush;    // software word into FIFO
    logic busPop;     // software word out of FIFO
    logic rxTake;     // card byte accepted this cycle
    logic rxLast;     // accepted byte is the last of the transfer
    logic txLoad;     // FIFO head moves into the byte shifter
    logic txShift;    // card took the low byte of the shifter
    logic startXfer;  // control write with enable set
    logic ctrlWr;     // any control write
  } dpStrobe_t;

endpackage

// File: rtl/cardFifoDatapath.sv
module cardFifoDatapath
  import cardFifoPkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 32
) (
  input  logic                              clk,
  input  logic                              rst,
  input  dpStrobe_t                         stb,
  input  logic [DATA_W-1:0]                 busWdata,
  input  logic [7:0]                        rxByte,
  output logic [DATA_W-1:0]                 fifoHead,
  output logic [$clog2(DEPTH+1)-1:0]        fifoCount,
  output logic                              fifoFull,
  output logic                              fifoEmpty,
  output logic                              txHas,
  output logic [7:0]                        txByte
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam int BYTES = DATA_W / 8;
  localparam int IDX_W = $clog2(BYTES);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  count;
  logic [DATA_W-1:0] packWord, rxWordNext, pushData, txWord;
  logic [IDX_W-1:0]  byteIdx;
  logic [IDX_W:0]    txLeft;
  logic              rxPush, push, pop;

  // Merge the incoming card byte into its lane of the partial word.
  for (genvar b = 0; b < BYTES; b++) begin : gLane
    assign rxWordNext[8*b +: 8] = (byteIdx == IDX_W'(b)) ? rxByte : packWord[8*b +: 8];
  end

  assign rxPush   = stb.rxTake && (byteIdx == IDX_W'(BYTES-1) || stb.rxLast);
  assign push     = stb.busPush || rxPush;
  assign pushData = stb.busPush ? busWdata : rxWordNext;
  assign pop      = stb.busPop || stb.txLoad;

  assign fifoHead  = mem[rdPtr];
  assign fifoCount = count;
  assign fifoFull  = (count == CNT_W'(DEPTH));
  assign fifoEmpty = (count == '0);
  assign txHas     = (txLeft != '0);
  assign txByte    = txWord[7:0];

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      count    <= '0;
      packWord <= '0;
      byteIdx  <= '0;
      txWord   <= '0;
      txLeft   <= '0;
    end else begin
      if (push) wrPtr <= (wrPtr == PTR_W'(DEPTH-1)) ? '0 : wrPtr + 1'b1;
      if (pop)  rdPtr <= (rdPtr == PTR_W'(DEPTH-1)) ? '0 : rdPtr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase

      if (stb.startXfer) begin
        packWord <= '0;
        byteIdx  <= '0;
      end else if (stb.rxTake) begin
        if (rxPush) begin
          packWord <= '0;
          byteIdx  <= '0;
        end else begin
          packWord <= rxWordNext;
          byteIdx  <= byteIdx + 1'b1;
        end
      end

      if (stb.startXfer) begin
        txLeft <= '0;
      end else if (stb.txLoad) begin
        txWord <= fifoHead;
        txLeft <= (IDX_W+1)'(BYTES);
      end else if (stb.txShift) begin
        txWord <= txWord >> 8;
        txLeft <= txLeft - 1'b1;
      end
    end
  end

endmodule

// File: rtl/cardFifoControl.sv
module cardFifoControl
  import cardFifoPkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        regWrEn,
  input  logic                        regRdEn,
  input  logic [7:0]                  regAddr,
  input  logic [DATA_W-1:0]           regWdata,
  output logic [DATA_W-1:0]           regRdata,
  input  logic                        cardRxValid,
  output logic                        cardRxReady,
  input  logic                        cardTxReady,
  output logic                        cardTxValid,
  input  logic [DATA_W-1:0]           fifoHead,
  input  logic                        fifoFull,
  input  logic                        fifoEmpty,
  input  logic                        txHas,
  output dpStrobe_t                   stb,
  output logic [LEN_W-1:0]            remaining,
  output logic                        deferred
);
  logic [LEN_W-1:0] lenReg;
  logic             enable, dirRead, blockEnd;
  logic             isLen, isCtrl, isRem, isStat, isWcnt, isFifo;
  logic             remZero, done;
  logic [LEN_W:0]   wordCnt;
  logic [4:0]       statusBits;

  assign isLen  = (regAddr == 8'h00);
  assign isCtrl = (regAddr == 8'h04);
  assign isRem  = (regAddr == 8'h08);
  assign isStat = (regAddr == 8'h0C);
  assign isWcnt = (regAddr == 8'h10);
  assign isFifo = (regAddr[7:6] == 2'b10) && (regAddr[1:0] == 2'b00);

  assign remZero = (remaining == '0);
  assign done    = enable && remZero && fifoEmpty;
  assign wordCnt = ({1'b0, remaining} + (LEN_W+1)'(3)) >> 2;

  assign cardRxReady = enable && dirRead && !remZero && !fifoFull && !deferred;
  assign cardTxValid = enable && !dirRead && !remZero && txHas;

  always_comb begin
    stb           = '0;
    stb.ctrlWr    = regWrEn && isCtrl;
    stb.startXfer = regWrEn && isCtrl && regWdata[0];
    stb.busPush   = regWrEn && isFifo && enable && !dirRead && !remZero && !fifoFull;
    stb.busPop    = regRdEn && isFifo && !fifoEmpty;
    stb.rxTake    = cardRxValid && cardRxReady;
    stb.rxLast    = (remaining == LEN_W'(1));
    stb.txShift   = cardTxValid && cardTxReady;
    stb.txLoad    = enable && !dirRead && !remZero && !txHas && !fifoEmpty && !stb.busPop;
  end

  assign statusBits = {fifoFull, fifoEmpty, enable && !dirRead, enable && dirRead, blockEnd};

  always_comb begin
    regRdata = '0;
    if (isLen)       regRdata = DATA_W'(lenReg);
    else if (isCtrl) regRdata = DATA_W'({dirRead, enable});
    else if (isRem)  regRdata = DATA_W'(remaining);
    else if (isStat) regRdata = DATA_W'(statusBits);
    else if (isWcnt) regRdata = DATA_W'(wordCnt);
    else if (isFifo) regRdata = fifoEmpty ? '0 : fifoHead;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lenReg    <= '0;
      enable    <= 1'b0;
      dirRead   <= 1'b0;
      remaining <= '0;
      deferred  <= 1'b0;
      blockEnd  <= 1'b0;
    end else begin
      if (regWrEn && isLen) lenReg <= regWdata[LEN_W-1:0];

      if (stb.ctrlWr) begin
        enable  <= regWdata[0];
        dirRead <= regWdata[1];
      end else if (done) begin
        enable <= 1'b0;
      end

      if (stb.startXfer)                  remaining <= lenReg;
      else if (stb.rxTake || stb.txShift) remaining <= remaining - 1'b1;

      if (stb.startXfer) blockEnd <= 1'b0;
      else if (done)     blockEnd <= 1'b1;

      if (stb.startXfer)                    deferred <= 1'b0;
      else if (regRdEn && (isStat || isWcnt)) deferred <= 1'b0;
      else if (stb.busPop)                  deferred <= 1'b1;
    end
  end

endmodule

// File: rtl/cardFifoEngine.sv
module cardFifoEngine
  import cardFifoPkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [7:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              cardRxValid,
  input  logic [7:0]        cardRxByte,
  output logic              cardRxReady,
  output logic              cardTxValid,
  output logic [7:0]        cardTxByte,
  input  logic              cardTxReady
);
  localparam int CNT_W = $clog2(DEPTH+1);

  dpStrobe_t         stb;
  logic [DATA_W-1:0] fifoHead;
  logic [CNT_W-1:0]  fifoCount;
  logic              fifoFull, fifoEmpty, txHas, deferred;
  logic [LEN_W-1:0]  remaining;

  cardFifoControl #(.DEPTH(DEPTH), .DATA_W(DATA_W), .LEN_W(LEN_W)) uCtrl (
    .clk(clk), .rst(rst),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata),
    .cardRxValid(cardRxValid), .cardRxReady(cardRxReady),
    .cardTxReady(cardTxReady), .cardTxValid(cardTxValid),
    .fifoHead(fifoHead), .fifoFull(fifoFull), .fifoEmpty(fifoEmpty),
    .txHas(txHas), .stb(stb), .remaining(remaining), .deferred(deferred)
  );

  cardFifoDatapath #(.DEPTH(DEPTH), .DATA_W(DATA_W)) uData (
    .clk(clk), .rst(rst), .stb(stb),
    .busWdata(regWdata), .rxByte(cardRxByte),
    .fifoHead(fifoHead), .fifoCount(fifoCount),
    .fifoFull(fifoFull), .fifoEmpty(fifoEmpty),
    .txHas(txHas), .txByte(cardTxByte)
  );

endmodule

// File: rtl/cardFifoChecker.sv
module cardFifoChecker
  import cardFifoPkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LEN_W = 16
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       cardRxValid,
  input logic                       cardRxReady,
  input logic                       cardTxValid,
  input logic                       cardTxReady,
  input logic [7:0]                 cardTxByte,
  input logic [LEN_W-1:0]           remaining,
  input logic [$clog2(DEPTH+1)-1:0] fifoCount,
  input logic                       fifoFull,
  input logic                       deferred,
  input dpStrobe_t                  stb
);
  localparam int CNT_W = $clog2(DEPTH+1);

  assert_no_overflow_R12: assert property (@(posedge clk) disable iff (rst)
    fifoFull |-> !cardRxReady);

  assert_count_bound_R12: assert property (@(posedge clk) disable iff (rst)
    fifoCount <= CNT_W'(DEPTH));

  assert_hold_while_deferred_R6: assert property (@(posedge clk) disable iff (rst)
    deferred |-> !cardRxReady);

  assert_byte_step_R4: assert property (@(posedge clk) disable iff (rst)
    (((cardRxValid && cardRxReady) || (cardTxValid && cardTxReady)) && !stb.startXfer)
      |=> remaining == $past(remaining) - 1'b1);

  assert_tx_stable_R10: assert property (@(posedge clk) disable iff (rst)
    (cardTxValid && !cardTxReady && !stb.ctrlWr) |=> (cardTxValid && $stable(cardTxByte)));

  assert_one_direction_R7: assert property (@(posedge clk) disable iff (rst)
    !(cardRxReady && cardTxValid));

endmodule

bind cardFifoEngine cardFifoChecker #(.DEPTH(DEPTH), .LEN_W(LEN_W)) uChk (
  .clk(clk), .rst(rst),
  .cardRxValid(cardRxValid), .cardRxReady(cardRxReady),
  .cardTxValid(cardTxValid), .cardTxReady(cardTxReady),
  .cardTxByte(cardTxByte), .remaining(remaining),
  .fifoCount(fifoCount), .fifoFull(fifoFull),
  .deferred(deferred), .stb(stb)
);

// File: tb/tb_cardFifoEngine.sv
module tb_cardFifoEngine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        cardRxValid = 1'b0;
  logic [7:0]  cardRxByte = '0;
  logic        cardRxReady, cardTxValid, cardTxReady = 1'b0;
  logic [7:0]  cardTxByte;

  int total = 0, bad = 0;
  bit rxOn = 0, rxPend = 0;
  int rxIdx = 0, txN = 0;
  logic [7:0]  txLog [0:4095];
  logic [31:0] wd [0:15];

  always #10 clk = ~clk;

  cardFifoEngine dut (
    .clk(clk), .rst(rst), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .cardRxValid(cardRxValid), .cardRxByte(cardRxByte), .cardRxReady(cardRxReady),
    .cardTxValid(cardTxValid), .cardTxByte(cardTxByte), .cardTxReady(cardTxReady)
  );

  function automatic logic [7:0] srcByte(int i);
    return 8'(i * 73 + 11);
  endfunction

  // Expected FIFO word w of a card-to-FIFO transfer of len bytes starting at card byte base.
  function automatic logic [31:0] packExp(int base, int w, int len);
    logic [31:0] r = '0;
    for (int k = 0; k < 4; k++)
      if (4*w + k < len) r[8*k +: 8] = srcByte(base + 4*w + k);
    return r;
  endfunction

  // Card model: decisions at the falling edge, handshakes at the next rising edge.
  always @(negedge clk) begin
    if (rxPend) rxIdx++;
    cardRxValid = rxOn && ($urandom % 4 != 0);
    cardRxByte  = srcByte(rxIdx);
    rxPend      = cardRxValid && cardRxReady;
    cardTxReady = ($urandom % 3 != 0);
    if (cardTxValid && cardTxReady) begin
      txLog[txN % 4096] = cardTxByte;
      txN++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    #5 d = regRdata;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic waitRem(input int target);
    logic [31:0] v;
    for (int i = 0; i < 3000; i++) begin
      busRead(8'h08, v);
      if (v == 32'(target)) break;
    end
  endtask

  task automatic rxRun(input int len);
    logic [31:0] v;
    int base = rxIdx;
    busWrite(8'h00, 32'(len));
    busWrite(8'h04, 32'h3);
    rxOn = 1;
    waitRem(0);
    rxOn = 0;
    repeat (2) @(negedge clk);
    for (int w = 0; w < (len + 3) / 4; w++) begin
      busRead(8'h80 + 8'(4 * (w % 16)), v);
      chk((4*w + 4 > len) ? "R3 partial word" : "R2/R11 packed word", v, packExp(base, w, len));
    end
    repeat (3) @(negedge clk);
    busRead(8'h0C, v); chk("R7 rx status at end", v, 32'h09);
    busRead(8'h04, v); chk("R7 rx enable cleared", v, 32'h2);
  endtask

  task automatic txRun(input int len);
    logic [31:0] v;
    int start = txN;
    busWrite(8'h00, 32'(len));
    busWrite(8'h04, 32'h1);
    for (int w = 0; w < (len + 3) / 4; w++) begin
      wd[w] = $urandom;
      busWrite(8'h80 + 8'(4 * ((w * 5) % 16)), wd[w]);
    end
    waitRem(0);
    repeat (4) @(negedge clk);
    chk("R10 byte count", 32'(txN - start), 32'(len));
    for (int i = 0; i < len; i++)
      chk("R10 byte order", 32'(txLog[(start + i) % 4096]), 32'(wd[i/4][8*(i%4) +: 8]));
    busRead(8'h0C, v); chk("R7 tx status at end", v, 32'h09);
    busRead(8'h04, v); chk("R7 tx enable cleared", v, 32'h0);
  endtask

  initial begin
    #(20 * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int base;
    int lens [5] = '{1, 4, 5, 63, 65535};
    void'($urandom(32'h5eed1234));
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 rx ready", 32'(cardRxReady), 32'h0);
    chk("R1 tx valid", 32'(cardTxValid), 32'h0);
    busRead(8'h0C, v); chk("R1 status", v, 32'h08);
    busRead(8'h08, v); chk("R1 remaining", v, 32'h0);
    busRead(8'h10, v); chk("R1 word count", v, 32'h0);
    busRead(8'h04, v); chk("R1 control", v, 32'h0);

    // R4 / R5 count load and rounding
    foreach (lens[i]) begin
      busWrite(8'h00, 32'(lens[i]));
      busWrite(8'h04, 32'h3);
      busRead(8'h10, v); chk("R5 word count", v, 32'((lens[i] + 3) >> 2));
      busRead(8'h08, v); chk("R4 remaining load", v, 32'(lens[i]));
      busWrite(8'h04, 32'h0);
    end

    // R7 zero-length transfer
    busWrite(8'h00, 32'h0);
    busWrite(8'h04, 32'h3);
    repeat (2) @(negedge clk);
    busRead(8'h0C, v); chk("R7 zero length done", v, 32'h09);

    // R8 empty read, no hold
    base = rxIdx;
    busWrite(8'h00, 32'h4);
    busWrite(8'h04, 32'h3);
    busRead(8'h80, v); chk("R8 empty read zero", v, 32'h0);
    rxOn = 1;
    repeat (30) @(negedge clk);
    busRead(8'h08, v); chk("R8 no hold after empty read", v, 32'h0);
    rxOn = 0;
    busRead(8'hBC, v); chk("R11 alias 0xBC", v, packExp(base, 0, 4));

    // R9 FIFO write in the wrong direction is dropped
    base = rxIdx;
    busWrite(8'h00, 32'h4);
    busWrite(8'h04, 32'h3);
    busWrite(8'h80, 32'hDEADBEEF);
    busRead(8'h0C, v); chk("R9 write dropped in rx", v, 32'h0A);
    rxOn = 1;
    waitRem(0);
    rxOn = 0;
    busRead(8'h80, v); chk("R2 word after dropped write", v, packExp(base, 0, 4));

    // directed lengths, both directions
    rxRun(1); rxRun(3); rxRun(4); rxRun(64);
    txRun(1); txRun(3); txRun(4); txRun(64);

    // R9 write after completion ignored
    busWrite(8'h84, 32'hCAFEF00D);
    busRead(8'h0C, v); chk("R9 write ignored at zero count", v, 32'h09);
    busRead(8'h08, v); chk("R9 remaining still zero", v, 32'h0);

    // random lengths
    for (int it = 0; it < 8; it++) begin
      if (it % 2 == 0) rxRun(1 + int'($urandom % 64));
      else             txRun(1 + int'($urandom % 64));
    end

    // R6 / R12 hold after pop and full-FIFO stall
    base = rxIdx;
    busWrite(8'h00, 32'd80);
    busWrite(8'h04, 32'h3);
    rxOn = 1;
    waitRem(16);
    repeat (10) @(negedge clk);
    busRead(8'h08, v); chk("R12 stall when full", v, 32'd16);
    busRead(8'h80, v); chk("R2 first word", v, packExp(base, 0, 80));
    repeat (10) @(negedge clk);
    busRead(8'h08, v); chk("R6 held after pop", v, 32'd16);
    busRead(8'h0C, v);
    repeat (20) @(negedge clk);
    busRead(8'h08, v); chk("R6 resumed after status read", v, 32'd12);
    for (int w = 1; w < 20; w++) begin
      busRead(8'h80 + 8'(4 * (w % 16)), v);
      chk("R2 drained word", v, packExp(base, w, 80));
      busRead(8'h10, v);
      repeat (8) @(negedge clk);
    end
    rxOn = 0;
    repeat (4) @(negedge clk);
    busRead(8'h0C, v); chk("R7 end after long read", v, 32'h09);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule